// File: doc/BRIEF.md
# TDM Input Stream Frame Aligner

The block takes one serial PCM stream and lines it up against a master frame pulse shared by the whole system. Each stream may arrive late relative to that pulse, so the block has a two-part offset. A whole-channel part moves the stream's channel 0 to any channel slot of the frame. A fractional part, counted in quarter-bit steps, moves the sampling point within a bit and across up to almost eight bits. Together they place channel 0 anywhere in the frame with quarter-bit resolution.

The block runs on a clock at four times the serial bit rate. The bit-delay value selects which sample of each bit is captured. The captured bits are gathered most significant bit first into a byte. Each completed byte is tagged with its corrected channel number and marked by a one-cycle strobe. A small write-only register port sets the channel delay, the bit delay and the rate. The rate is either 128 channels per frame (the lower rate) or 256 channels per frame (the doubled rate). New settings are held in shadow registers and take effect at the next frame pulse.

Top module: `tdm_frame_aligner`

## Requirements
- R1: After reset, `valid_o`, `byte_o` and `chan_o` are zero, both delays are zero and the lower rate is active.
- R2: With zero delays, the byte captured in the first channel slot after the frame pulse is tagged channel 0.
- R3: With channel delay c, the byte in slot k after the pulse is tagged (k - c) mod N, where N is the channel count. With c=1, channel N-1 comes first and channel 0 second. With c=2, channel N-2 comes first.
- R4: Register writes made during a frame do not change the tagging or the sampling of that frame. They take effect from the next frame pulse.
- R5: The bit delay is a 5-bit value in quarter-bit units, so bits 4:2 are whole bits and bits 1:0 are quarters. A stream shifted late by that many samples is captured unchanged. The sample taken is the third of the four samples of each delayed bit.
- R6: The first bit received for a channel becomes bit 7 of `byte_o`.
- R7: Rate value 0 gives 128 channels and 4096 clock cycles per frame. Rate value 1 gives 256 channels and 8192 clock cycles. Channel numbers wrap modulo the active channel count.
- R8: `valid_o` pulses for exactly one cycle per channel slot, which is N times per frame. It rises one clock after the eighth bit of the byte is captured.
- R9: Register writes happen only while `reg_we_i` is high. Address 0 is the channel delay, address 1 takes the bit delay from bits 4:0, and address 2 takes the rate from bit 0. A write to address 3 changes nothing.

Rate select and channel-delay semantics above are given in terms of N, the active channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock at four times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_pulse_i | input | 1 | Master frame pulse, one cycle, on the first sample of a frame |
| ser_i | input | 1 | Serial PCM input |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| byte_o | output | 8 | Assembled channel byte |
| chan_o | output | 8 | Corrected channel number of `byte_o` |
| valid_o | output | 1 | One-cycle strobe for `byte_o` and `chan_o` |

## Verification
Each frame carries a fresh random byte per channel. The stream is shifted late by exactly channel delay × 32 plus bit delay samples, so a wrong offset shows up as wrong bytes on the correct channel tags. Directed settings cover zero delay, one and two channels, and the largest channel and quarter-bit values at both rates. Random settings fill the space between them. A fixed channel-0 pattern that differs from its bit reversal separates MSB-first assembly from LSB-first. Writes in the middle of a checked frame show whether the settings wait for the pulse. A write with enable low and a write to the unused address are followed by a full check of the frame.

// File: rtl/tfa_pkg.sv
`timescale 1ns/1ps
package tfa_pkg;
  typedef enum logic [1:0] {
    ADDR_CH_DLY  = 2'd0,
    ADDR_BIT_DLY = 2'd1,
    ADDR_RATE    = 2'd2
  } tfa_addr_e;
endpackage

// File: rtl/tfa_cfg.sv
`timescale 1ns/1ps
module tfa_cfg #(
  parameter int CH_W = 8,
  parameter int BD_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      addr_i,
  input  logic [CH_W-1:0] wdata_i,
  input  logic            fp_i,
  output logic [CH_W-1:0] act_cd_o,
  output logic [BD_W-1:0] act_bd_o,
  output logic            act_hi_o,
  output logic [CH_W-1:0] eff_cd_o,
  output logic [BD_W-1:0] eff_bd_o,
  output logic            eff_hi_o
);
  import tfa_pkg::*;

  logic [CH_W-1:0] shd_cd_q;
  logic [BD_W-1:0] shd_bd_q;
  logic            shd_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_cd_q <= '0;
      shd_bd_q <= '0;
      shd_hi_q <= 1'b0;
    end else if (we_i) begin
      case (tfa_addr_e'(addr_i))
        ADDR_CH_DLY:  shd_cd_q <= wdata_i;
        ADDR_BIT_DLY: shd_bd_q <= wdata_i[BD_W-1:0];
        ADDR_RATE:    shd_hi_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // shadow values become active only on the frame pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cd_o <= '0;
      act_bd_o <= '0;
      act_hi_o <= 1'b0;
    end else if (fp_i) begin
      act_cd_o <= shd_cd_q;
      act_bd_o <= shd_bd_q;
      act_hi_o <= shd_hi_q;
    end
  end

  assign eff_cd_o = fp_i ? shd_cd_q : act_cd_o;
  assign eff_bd_o = fp_i ? shd_bd_q : act_bd_o;
  assign eff_hi_o = fp_i ? shd_hi_q : act_hi_o;
endmodule

// File: rtl/tfa_slot_cnt.sv
`timescale 1ns/1ps
module tfa_slot_cnt #(
  parameter int POS_W = 13,
  parameter int BD_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic             hi_i,
  input  logic [BD_W-1:0]  bd_i,
  output logic [POS_W-1:0] cnt_o,
  output logic [POS_W-1:0] dpos_o
);
  logic [POS_W-1:0] mask;
  logic [POS_W-1:0] pos;

  // the lower rate halves the frame: drop the top position bit
  assign mask = hi_i ? {POS_W{1'b1}} : {1'b0, {(POS_W-1){1'b1}}};
  assign pos  = fp_i ? '0 : cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= (pos + POS_W'(1)) & mask;
  end

  // position inside the delayed stream frame
  assign dpos_o = (pos - POS_W'(bd_i)) & mask;
endmodule

// File: rtl/tfa_deser.sv
`timescale 1ns/1ps
module tfa_deser #(
  parameter int POS_W = 13,
  parameter int CH_W  = 8,
  parameter int PH_W  = 2,
  parameter int BIT_W = 3,
  parameter int NB    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic [POS_W-1:0] dpos_i,
  input  logic [CH_W-1:0]  cd_i,
  input  logic             hi_i,
  output logic [NB-1:0]    byte_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             valid_o
);
  localparam int PH_SAMPLE = (1 << PH_W) / 2;

  logic            capture;
  logic            last_bit;
  logic [CH_W-1:0] raw_slot;
  logic [CH_W-1:0] ch_mask;
  logic [CH_W-1:0] chan_nxt;
  logic [NB-2:0]   sh_q;
  logic [NB-1:0]   sh_nxt;

  assign capture  = dpos_i[PH_W-1:0] == PH_W'(PH_SAMPLE);
  assign last_bit = capture && (dpos_i[PH_W +: BIT_W] == {BIT_W{1'b1}});
  assign raw_slot = dpos_i[POS_W-1 -: CH_W];
  assign ch_mask  = hi_i ? {CH_W{1'b1}} : {1'b0, {(CH_W-1){1'b1}}};
  assign chan_nxt = (raw_slot - cd_i) & ch_mask;
  assign sh_nxt   = {sh_q, ser_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      byte_o  <= '0;
      chan_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_bit;
      if (capture) sh_q <= sh_nxt[NB-2:0];
      if (last_bit) begin
        byte_o <= sh_nxt;
        chan_o <= chan_nxt;
      end
    end
  end
endmodule

// File: rtl/tdm_frame_aligner.sv
`timescale 1ns/1ps
module tdm_frame_aligner #(
  parameter int NUM_CH_HI   = 256,
  parameter int BITS_PER_CH = 8,
  parameter int OVERSAMPLE  = 4,
  parameter int BIT_DLY_W   = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_pulse_i,
  input  logic                          ser_i,
  input  logic                          reg_we_i,
  input  logic [1:0]                    reg_addr_i,
  input  logic [$clog2(NUM_CH_HI)-1:0]  reg_wdata_i,
  output logic [BITS_PER_CH-1:0]        byte_o,
  output logic [$clog2(NUM_CH_HI)-1:0]  chan_o,
  output logic                          valid_o
);
  localparam int CH_W  = $clog2(NUM_CH_HI);
  localparam int BIT_W = $clog2(BITS_PER_CH);
  localparam int PH_W  = $clog2(OVERSAMPLE);
  localparam int POS_W = CH_W + BIT_W + PH_W;

  logic [CH_W-1:0]      act_cd, eff_cd;
  logic [BIT_DLY_W-1:0] act_bd, eff_bd;
  logic                 act_hi, eff_hi;
  logic [POS_W-1:0]     cnt;
  logic [POS_W-1:0]     dpos;

  tfa_cfg #(.CH_W(CH_W), .BD_W(BIT_DLY_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .fp_i    (frame_pulse_i),
    .act_cd_o(act_cd),
    .act_bd_o(act_bd),
    .act_hi_o(act_hi),
    .eff_cd_o(eff_cd),
    .eff_bd_o(eff_bd),
    .eff_hi_o(eff_hi)
  );

  tfa_slot_cnt #(.POS_W(POS_W), .BD_W(BIT_DLY_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fp_i  (frame_pulse_i),
    .hi_i  (eff_hi),
    .bd_i  (eff_bd),
    .cnt_o (cnt),
    .dpos_o(dpos)
  );

  tfa_deser #(
    .POS_W(POS_W), .CH_W(CH_W), .PH_W(PH_W), .BIT_W(BIT_W), .NB(BITS_PER_CH)
  ) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .dpos_i (dpos),
    .cd_i   (eff_cd),
    .hi_i   (eff_hi),
    .byte_o (byte_o),
    .chan_o (chan_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/tdm_frame_aligner_chk.sv
`timescale 1ns/1ps
module tdm_frame_aligner_chk #(
  parameter int NUM_CH_HI   = 256,
  parameter int BITS_PER_CH = 8,
  parameter int OVERSAMPLE  = 4,
  parameter int BIT_DLY_W   = 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          frame_pulse_i,
  input logic                          valid_o,
  input logic [$clog2(NUM_CH_HI)-1:0]  chan_o,
  input logic [$clog2(NUM_CH_HI)-1:0]  act_cd,
  input logic [BIT_DLY_W-1:0]          act_bd,
  input logic                          act_hi,
  input logic                          eff_hi,
  input logic [$clog2(NUM_CH_HI)+$clog2(BITS_PER_CH)+$clog2(OVERSAMPLE)-1:0] cnt,
  input logic [$clog2(NUM_CH_HI)+$clog2(BITS_PER_CH)+$clog2(OVERSAMPLE)-1:0] dpos
);
  localparam int CH_W   = $clog2(NUM_CH_HI);
  localparam int BIT_W  = $clog2(BITS_PER_CH);
  localparam int PH_W   = $clog2(OVERSAMPLE);
  localparam int POS_W  = CH_W + BIT_W + PH_W;
  localparam int TAG_W  = BIT_W + PH_W;
  localparam logic [TAG_W-1:0] LAST_TAG = {{BIT_W{1'b1}}, PH_W'(OVERSAMPLE / 2)};

  a_r4_cfg_holds_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_pulse_i |=> ($stable(act_cd) && $stable(act_bd) && $stable(act_hi)));

  a_r7_count_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i |=> (cnt == POS_W'(1)));

  a_r7_low_rate_frame_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_hi && !frame_pulse_i) |=> !cnt[POS_W-1]);

  a_r3_low_rate_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(eff_hi)) |-> !chan_o[CH_W-1]);

  a_r8_strobe_after_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(dpos[TAG_W-1:0]) == LAST_TAG));
endmodule

bind tdm_frame_aligner tdm_frame_aligner_chk #(
  .NUM_CH_HI(NUM_CH_HI), .BITS_PER_CH(BITS_PER_CH),
  .OVERSAMPLE(OVERSAMPLE), .BIT_DLY_W(BIT_DLY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_pulse_i(frame_pulse_i),
  .valid_o      (valid_o),
  .chan_o       (chan_o),
  .act_cd       (act_cd),
  .act_bd       (act_bd),
  .act_hi       (act_hi),
  .eff_hi       (eff_hi),
  .cnt          (cnt),
  .dpos         (dpos)
);

// File: tb/tdm_frame_aligner_tb.sv
`timescale 1ns/1ps
module tdm_frame_aligner_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp = 1'b0;
  logic       ser = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] byte_o;
  logic [7:0] chan_o;
  logic       valid_o;

  always #5 clk = ~clk;

  tdm_frame_aligner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_pulse_i(fp), .ser_i(ser),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .byte_o(byte_o), .chan_o(chan_o), .valid_o(valid_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // stream currently driven, and the one waiting for the next pulse
  int s_cd = 0, s_bd = 0, s_hi = 0, s_F = 4096, s_N = 128;
  string s_tag = "R2";
  logic [7:0] s_mem [256];
  int n_cd, n_bd, n_hi;
  string n_tag;
  logic [7:0] n_mem [256];
  bit pending = 0, chk = 0, started = 0, r4flag = 0;
  int pos = 4095;
  int nvalid = 0;
  // sample presented at the previous edge
  int p_pos = 0, p_cd = 0, p_bd = 0, p_F = 4096, p_N = 128, p_hi = 0;
  bit p_chk = 0;
  string p_tag = "R2";
  logic [7:0] ch0_seen = '0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic stream_bit(int p);
    int t;
    int bi;
    t  = ((p - (s_cd * 32 + s_bd)) % s_F + s_F) % s_F;
    bi = t >> 2;
    return s_mem[bi >> 3][7 - (bi & 7)];
  endfunction

  task automatic tick();
    int dp;
    int exp_ch;
    bit ev;
    @(negedge clk);
    if (p_chk) begin
      dp = ((p_pos - p_bd) % p_F + p_F) % p_F;
      ev = (dp % 32) == 30;
      if (ev || valid_o) check(valid_o == ev, "R8", int'(valid_o), int'(ev));
      if (ev && valid_o) begin
        nvalid++;
        exp_ch = (((dp >> 5) - p_cd) % p_N + p_N) % p_N;
        check(int'(chan_o) == exp_ch, p_hi != 0 ? "R7" : "R3", int'(chan_o), exp_ch);
        check(byte_o == s_mem[exp_ch], p_tag, int'(byte_o), int'(s_mem[exp_ch]));
        if (exp_ch == 0) ch0_seen = byte_o;
      end
    end
    pos++;
    if (pos >= s_F) begin
      if (chk) check(nvalid == s_N, "R8", nvalid, s_N);
      pos = 0;
      nvalid = 0;
      if (pending) begin
        s_cd = n_cd; s_bd = n_bd; s_hi = n_hi;
        s_F = n_hi != 0 ? 8192 : 4096;
        s_N = n_hi != 0 ? 256 : 128;
        s_mem = n_mem;
        s_tag = n_tag;
        pending = 0;
        r4flag = 0;
        chk = 0;
      end else begin
        chk = started;
      end
      started = 1;
    end
    p_pos = pos; p_chk = chk; p_cd = s_cd; p_bd = s_bd;
    p_F = s_F; p_N = s_N; p_hi = s_hi;
    p_tag = r4flag ? "R4" : s_tag;
    fp  = (pos == 0);
    ser = stream_bit(pos);
  endtask

  task automatic wr(int a, int d, bit en);
    addr  = 2'(a);
    wdata = 8'(d);
    we    = en;
    tick();
    we = 1'b0;
  endtask

  task automatic run_cfg(int cd, int bd, int hi, string tag, bit junk);
    while (!(chk && pos == 200)) tick();
    for (int i = 0; i < 256; i++) n_mem[i] = 8'($urandom);
    n_mem[0] = 8'hC4;
    n_cd = cd; n_bd = bd; n_hi = hi; n_tag = tag;
    r4flag = 1;
    wr(0, cd, 1'b1);                // R9: address 0 channel delay
    wr(1, bd, 1'b1);                // R9: address 1 bit delay
    wr(2, hi, 1'b1);                // R9: address 2 rate
    if (junk) begin
      wr(0, 8'h55, 1'b0);           // R9: enable low, ignored
      wr(3, 8'hFF, 1'b1);           // R9: unused address, ignored
    end
    pending = 1;
    while (pending) tick();
    while (!chk) tick();
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) s_mem[i] = 8'($urandom);
    s_mem[0] = 8'hC4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of the outputs
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(byte_o == 8'h00, "R1", int'(byte_o), 0);
    check(chan_o == 8'h00, "R1", int'(chan_o), 0);
    // reset defaults, zero delay: R2 frames checked first
    run_cfg(1, 0, 0, "R3", 1'b0);
    // R6: 0xC4 differs from its bit reversal 0x23
    check(ch0_seen == 8'hC4, "R6", int'(ch0_seen), 8'hC4);
    run_cfg(2, 0, 0, "R3", 1'b0);
    run_cfg(127, 31, 0, "R5", 1'b0);
    run_cfg(5, 6, 0, "R9", 1'b1);
    run_cfg(int'($urandom % 128), int'($urandom % 32), 0, "R5", 1'b0);
    run_cfg(0, 0, 1, "R7", 1'b0);
    run_cfg(255, 31, 1, "R7", 1'b0);
    run_cfg(9, 5, 1, "R5", 1'b0);
    run_cfg(int'($urandom % 256), int'($urandom % 32), 1, "R7", 1'b0);
    run_cfg(3, 6, 0, "R7", 1'b0);
    tick();
    while (pos != 0) tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule